// File: doc/BRIEF.md
# Priority-Encoded Ready-Flag Dispatcher

This block collects one data-ready flag per converter input pair (13 pairs by default) and turns them into a branch address for a shared interrupt handler. Conversion logic pulses a per-pair set line when that pair's result is buffered. Software clears flags by writing zeros. Software loads a base register with the start of a jump table.

Reading the base register does not return the stored value alone. It returns the stored base plus four times the index of the highest-priority pending flag. Pair 0 has the highest priority. A common handler can therefore jump straight to the entry for the right pair. A per-pair enable mask gates the flags onto a single level-sensitive interrupt output.

The register port is a plain write strobe with a 2-bit register select and a combinational read bus. The select encoding is 0 = flags, 1 = base, 2 = enable mask, 3 = unused.

Top module: `rdy_vector_encoder`

## Requirements
- R1: After reset the flag register, the stored base and the enable mask are all zero, and `irq` is low.
- R2: A 1 on `set_pulse[k]` sets flag k, which is visible from the next clock edge. A read with select 0 returns the flags in bits 12..0, and bits 15..13 read as 0.
- R3: A write with select 0 clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. Writing a 1 never sets a flag.
- R4: When a set pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write with select 1 stores data bits 15..1 as the base. Bit 0 of the stored base is always 0.
- R6: A read with select 1 returns the stored base plus 4 times the lowest-numbered set flag index, so that pair 0 wins over all others.
- R7: With no flag set, a read with select 1 returns the stored base unchanged.
- R8: The select-1 read sum wraps modulo 2^16.
- R9: A write with select 2 stores the enable mask from data bits 12..0. A read with select 2 returns it with bits 15..13 at zero. `irq` is high exactly when some flag and its enable bit are both 1.
- R10: Select 3 reads as zero, and a write to it changes no flag, base or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 base, 2 enable, 3 unused |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `reg_sel` |
| set_pulse | input | 13 | Per-pair flag set pulses from the conversion logic |
| irq | output | 1 | Common interrupt, level |

## Verification
A corrupted flag bit shows up on the very next select-0 read. It also shifts the select-1 address, by a multiple of 4, whenever that bit is the lowest one set. A wrong priority or a wrong shift appears as a wrong jump address in the same cycle as the read. The bench therefore sweeps all 8192 flag patterns, each with its own base and enable mask, and compares the address and `irq` against arithmetic expectations one edge after the set pulse. A set/clear collision resolved the wrong way, or a write that leaks a 1 into the flags, is visible on the read one cycle after the write.

// File: rtl/rdy_vector_encoder.sv
module rdy_vector_encoder #(
  parameter int NPAIR = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [15:0]      wr_data,
  output logic [15:0]      rd_data,
  input  logic [NPAIR-1:0] set_pulse,
  output logic             irq
);
  localparam int IW = $clog2(NPAIR);

  logic [NPAIR-1:0] flags_q, ien_q;
  logic [14:0]      base_q;
  logic [IW-1:0]    win_idx;
  logic [15:0]      jump_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ien_q   <= '0;
      base_q  <= '0;
    end else begin
      if (wr_en && reg_sel == 2'd0) flags_q <= (flags_q & wr_data[NPAIR-1:0]) | set_pulse;
      else                          flags_q <= flags_q | set_pulse;
      if (wr_en && reg_sel == 2'd1) base_q <= wr_data[15:1];
      if (wr_en && reg_sel == 2'd2) ien_q  <= wr_data[NPAIR-1:0];
    end
  end

  always_comb begin
    win_idx = '0;
    for (int i = NPAIR - 1; i >= 0; i--)
      if (flags_q[i]) win_idx = IW'(i);
  end

  assign jump_addr = {base_q, 1'b0} + {{(14-IW){1'b0}}, win_idx, 2'b00};
  assign irq = |(flags_q & ien_q);

  always_comb begin
    case (reg_sel)
      2'd0:    rd_data = {{(16-NPAIR){1'b0}}, flags_q};
      2'd1:    rd_data = jump_addr;
      2'd2:    rd_data = {{(16-NPAIR){1'b0}}, ien_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rdy_vector_encoder_chk.sv
module rdy_vector_encoder_chk #(
  parameter int NPAIR = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       reg_sel,
  input logic [15:0]      wr_data,
  input logic [15:0]      rd_data,
  input logic [NPAIR-1:0] set_pulse,
  input logic [NPAIR-1:0] flags,
  input logic             irq
);
  // R2 R4
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse != '0 |=> (flags & $past(set_pulse)) == $past(set_pulse));

  // R3
  write_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0 && set_pulse == '0) |=> (flags & ~$past(flags)) == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && reg_sel == 2'd0) && set_pulse == '0) |=> $stable(flags));

  // R5
  addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel == 2'd1 |-> rd_data[0] == 1'b0);

  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags == '0 |-> !irq);
endmodule

bind rdy_vector_encoder rdy_vector_encoder_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
  .rd_data(rd_data), .set_pulse(set_pulse), .flags(flags_q), .irq(irq)
);

// File: tb/sim_rdy_vector_encoder.sv
`timescale 1ns/1ps
module sim_rdy_vector_encoder;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] wr_data = '0, rd_data;
  logic [12:0] set_pulse = '0;
  logic        irq;
  int          nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  rdy_vector_encoder u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .set_pulse(set_pulse), .irq(irq));

  task automatic cyc(input bit w, input logic [1:0] s, input logic [15:0] d, input logic [12:0] p);
    @(negedge clk);
    wr_en = w; reg_sel = s; wr_data = d; set_pulse = p;
    @(negedge clk);
    wr_en = 1'b0; set_pulse = '0;
  endtask

  task automatic chk(input string req, input logic [1:0] s, input logic [15:0] exp);
    reg_sel = s; #1;
    nchk++;
    if (rd_data !== exp) begin
      nfail++;
      $display("FAIL %s sel=%0d got %h exp %h", req, s, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input string req, input logic exp);
    #1; nchk++;
    if (irq !== exp) begin
      nfail++;
      $display("FAIL %s irq got %b exp %b", req, irq, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input logic [15:0] b, input logic [12:0] f);
    int k = 0;
    logic [16:0] s;
    for (int i = 12; i >= 0; i--) if (f[i]) k = i;
    s = {1'b0, b[15:1], 1'b0} + 17'(4 * k);
    return s[15:0];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 2'd0, 16'h0000);
    chk("R1", 2'd1, 16'h0000);
    chk("R1", 2'd2, 16'h0000);
    chk_irq("R1", 1'b0);
    rst_n = 1'b1;

    cyc(1'b1, 2'd1, 16'hFFFF, '0);
    chk("R5", 2'd1, 16'hFFFE);
    chk("R7", 2'd1, 16'hFFFE);

    cyc(1'b0, 2'd0, '0, 13'h1FFF);
    chk("R2", 2'd0, 16'h1FFF);
    cyc(1'b1, 2'd0, 16'hFFFF & 16'h1555, '0);
    chk("R3", 2'd0, 16'h1555);
    cyc(1'b1, 2'd0, 16'hFFFF, '0);
    chk("R3", 2'd0, 16'h1555);

    cyc(1'b1, 2'd0, 16'h0000, 13'h0010);
    chk("R4", 2'd0, 16'h0010);

    cyc(1'b1, 2'd3, 16'hFFFF, '0);
    chk("R10", 2'd3, 16'h0000);
    chk("R10", 2'd0, 16'h0010);
    chk("R10", 2'd2, 16'h0000);
    chk("R10", 2'd1, 16'hFFFE + 16'd16);

    cyc(1'b1, 2'd0, 16'h0000, '0);
    cyc(1'b1, 2'd1, 16'hFFFE, '0);
    cyc(1'b0, 2'd0, '0, 13'h1000);
    chk("R8", 2'd1, 16'h002E);

    for (int p = 0; p < 8192; p++) begin
      logic [15:0] b, e;
      b = 16'((p * 40503) ^ 16'h5A3C);
      e = 16'(((p * 7) ^ (p >> 3)) & 16'h1FFF);
      cyc(1'b1, 2'd0, 16'h0000, '0);
      cyc(1'b1, 2'd1, b, '0);
      cyc(1'b1, 2'd2, 16'hFFFF & e, '0);
      cyc(1'b0, 2'd0, '0, 13'(p));
      chk("R2", 2'd0, 16'(p));
      chk("R6", 2'd1, addr_of(b, 13'(p)));
      if (p % 64 == 0) chk("R9", 2'd2, e);
      chk_irq("R9", |(13'(p) & e[12:0]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule